// File: doc/BRIEF.md
# UART Interrupt Identity Encoder

This block turns the raw interrupt conditions of a 16550-style serial port into a single 4-bit identity code and one interrupt request line. It latches the event-type sources: receive line errors, a transmit-empty condition coming on, modem line changes, and a line-control write attempted while the port is busy. Each latched source is cleared by the register access that software uses to service it. Two sources are level-based: received data and the character timeout, which comes from an idle counter inside the block.

The code reports the highest-priority source that is both pending and enabled. The interrupt request is raised whenever that code is anything other than "none". Serial shifting, baud generation and the register file live elsewhere. The block only sees read and write strobes for the registers that matter to it.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no condition present, `irq_id` is 4'b0001 and `irq` is 0.
- R2: When more than one enabled source is pending, the code is chosen in this order: line status 4'b0110, then received data 4'b0100, then character timeout 4'b1100, then transmit empty 4'b0010, then modem status 4'b0000, then busy detect 4'b0111.
- R3: A pulse on any of `err_overrun`, `err_parity`, `err_framing` or `err_break` latches line status on that edge. `rd_lsr` clears it.
- R4: Received data is a level and is not latched. With `fifo_en`=0 it is pending while `rx_level` is non-zero. With `fifo_en`=1 it is pending while `rx_level` >= `rx_trig`, and it drops as soon as the level falls below the trigger.
- R5: With `fifo_en`=1 and `rx_level` non-zero, the character timeout latches on the edge that completes TO_CHARS*CHAR_CYC consecutive edges with neither `rx_push` nor `rx_pop`. Any push or pop restarts the count. `rd_rbr` clears the timeout.
- R6: The transmit condition is `thr_empty` when `prog_thr_en`=0, and `tx_level` <= `tx_thresh` when `prog_thr_en`=1. Its 0-to-1 change latches transmit empty; the condition's previous value is 0 after reset. Transmit empty is cleared by `wr_thr`, or by `rd_iir` in a cycle where `irq_id` reads 4'b0010.
- R7: A change on any bit of `modem_lines` relative to the previous cycle latches modem status. The previous value is 0 after reset. `rd_msr` clears it.
- R8: `lcr_write` while `busy` is high latches busy detect, and `rd_usr` clears it.
- R9: Each source is gated by a bit of `irq_en`: bit 0 received data and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status, bit 4 busy detect. A masked source is neither reported nor raises `irq`. It still latches, and it appears once its bit is set.
- R10: `irq` is 1 exactly when `irq_id` differs from 4'b0001.
- R11: When a latched source sees its setting event and its clearing action on the same edge, it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Receive/transmit FIFOs enabled |
| prog_thr_en | input | 1 | Transmit empty judged by FIFO threshold |
| irq_en | input | 5 | Per-source enable bits |
| err_overrun | input | 1 | Receive overrun event |
| err_parity | input | 1 | Parity error event |
| err_framing | input | 1 | Framing error event |
| err_break | input | 1 | Break detected event |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_pop | input | 1 | Character read out of receive FIFO |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_thresh | input | LVL_W | Programmable transmit threshold |
| modem_lines | input | 4 | CTS, DSR, RI, DCD inputs |
| lcr_write | input | 1 | Write strobe to line control register |
| busy | input | 1 | Port busy flag |
| rd_lsr | input | 1 | Read strobe, line status register |
| rd_rbr | input | 1 | Read strobe, receive buffer |
| rd_iir | input | 1 | Read strobe, identity register |
| rd_msr | input | 1 | Read strobe, modem status register |
| rd_usr | input | 1 | Read strobe, port status register |
| wr_thr | input | 1 | Write strobe, transmit holding register |
| irq_id | output | 4 | Interrupt identity code |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same edge. The first is a latched source's setting event arriving together with its own clearing access, for example an error pulse together with `rd_lsr`. The bench drives both strobes high for one cycle, and the expected result is that line status stays reported afterward. The second is an `rd_iir` while transmit empty is the reported code: the clear applies only if the code seen in that very cycle is 4'b0010. The bench therefore also issues `rd_iir` while a higher source hides transmit empty, and expects transmit empty to survive. A behavioural reference model compares code and request on every cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM = 4'h0,
        ID_NONE  = 4'h1,
        ID_TXE   = 4'h2,
        ID_RXD   = 4'h4,
        ID_LINE  = 4'h6,
        ID_BUSY  = 4'h7,
        ID_TOUT  = 4'hC
    } irq_id_e;

    localparam int N_EN     = 5;
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_BUSY  = 4;

    localparam int N_FLAG   = 4;
    localparam int FL_LINE  = 0;
    localparam int FL_TX    = 1;
    localparam int FL_MODEM = 2;
    localparam int FL_BUSY  = 3;

    typedef struct packed {
        logic line;
        logic rxd;
        logic tout;
        logic txe;
        logic modem;
        logic busy;
    } src_t;

    function automatic irq_id_e pick_id(src_t s, logic [N_EN-1:0] en);
        if (s.line && en[EN_LINE])        return ID_LINE;
        else if (s.rxd && en[EN_RX])      return ID_RXD;
        else if (s.tout && en[EN_RX])     return ID_TOUT;
        else if (s.txe && en[EN_TX])      return ID_TXE;
        else if (s.modem && en[EN_MODEM]) return ID_MODEM;
        else if (s.busy && en[EN_BUSY])   return ID_BUSY;
        else                              return ID_NONE;
    endfunction

endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    // a set on the same edge as a clear keeps the flag up
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/uirq_timeout.sv
module uirq_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic activity,
    input  logic clr,
    output logic pend
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          counting;
    logic          hit;

    assign counting = armed && !activity;
    assign hit      = counting && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (!counting)
                cnt <= '0;
            else if (cnt != CW'(LIMIT))
                cnt <= cnt + 1'b1;
            if (hit)      pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  src_t            src,
    input  logic [N_EN-1:0] en,
    output irq_id_e         id
);
    always_comb id = pick_id(src, en);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int CHAR_CYC = 16,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic             prog_thr_en,
    input  logic [4:0]       irq_en,
    input  logic             err_overrun,
    input  logic             err_parity,
    input  logic             err_framing,
    input  logic             err_break,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             thr_empty,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [3:0]       modem_lines,
    input  logic             lcr_write,
    input  logic             busy,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             rd_iir,
    input  logic             rd_msr,
    input  logic             rd_usr,
    input  logic             wr_thr,
    output logic [3:0]       irq_id,
    output logic             irq
);
    localparam int TO_LIMIT = CHAR_CYC * TO_CHARS;

    logic              tx_cond, tx_cond_q;
    logic [3:0]        lines_q;
    logic [N_FLAG-1:0] fl_set, fl_clr, fl_q;
    logic              rx_avail, tout_pend;
    src_t              src;
    irq_id_e           cur_id;

    assign tx_cond  = prog_thr_en ? (tx_level <= tx_thresh) : thr_empty;
    assign rx_avail = fifo_en ? (rx_level >= rx_trig) : (rx_level != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_cond_q <= 1'b0;
            lines_q   <= '0;
        end else begin
            tx_cond_q <= tx_cond;
            lines_q   <= modem_lines;
        end
    end

    always_comb begin
        fl_set[FL_LINE]  = err_overrun | err_parity | err_framing | err_break;
        fl_clr[FL_LINE]  = rd_lsr;
        fl_set[FL_TX]    = tx_cond & ~tx_cond_q;
        fl_clr[FL_TX]    = wr_thr | (rd_iir && cur_id == ID_TXE);
        fl_set[FL_MODEM] = modem_lines != lines_q;
        fl_clr[FL_MODEM] = rd_msr;
        fl_set[FL_BUSY]  = lcr_write & busy;
        fl_clr[FL_BUSY]  = rd_usr;
    end

    for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
        uirq_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (fl_set[g]),
            .clr (fl_clr[g]),
            .q   (fl_q[g])
        );
    end

    uirq_timeout #(.LIMIT(TO_LIMIT)) u_tout (
        .clk      (clk),
        .rst      (rst),
        .armed    (fifo_en && rx_level != '0),
        .activity (rx_push | rx_pop),
        .clr      (rd_rbr),
        .pend     (tout_pend)
    );

    always_comb begin
        src.line  = fl_q[FL_LINE];
        src.rxd   = rx_avail;
        src.tout  = tout_pend;
        src.txe   = fl_q[FL_TX];
        src.modem = fl_q[FL_MODEM];
        src.busy  = fl_q[FL_BUSY];
    end

    uirq_prio u_prio (
        .src (src),
        .en  (irq_en),
        .id  (cur_id)
    );

    assign irq_id = cur_id;
    assign irq    = cur_id != ID_NONE;
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       irq_en,
    input logic             err_any,
    input logic             rd_lsr,
    input logic             lcr_write,
    input logic             busy,
    input logic             fifo_en,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] rx_trig,
    input logic [3:0]       irq_id,
    input logic             tout_pend
);
    p_line_set_r3: assert property (@(posedge clk) disable iff (rst)
        (err_any && irq_en[2]) |=> (irq_id == 4'h6 || !irq_en[2]));

    p_line_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !err_any) |=> (irq_id != 4'h6));

    p_busy_set_r8: assert property (@(posedge clk) disable iff (rst)
        (lcr_write && busy && irq_en[4]) |=> (irq_id != 4'h1 || !irq_en[4]));

    p_rx_level_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_en[0] && fifo_en && rx_level >= rx_trig && irq_id != 4'h6) |-> (irq_id == 4'h4));

    p_tout_armed_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(tout_pend) |-> $past(fifo_en && rx_level != '0));

    p_id_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_id inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'h7, 4'hC}));
endmodule

bind uart_irq_ident uirq_checker #(.LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_en    (irq_en),
    .err_any   (err_overrun | err_parity | err_framing | err_break),
    .rd_lsr    (rd_lsr),
    .lcr_write (lcr_write),
    .busy      (busy),
    .fifo_en   (fifo_en),
    .rx_level  (rx_level),
    .rx_trig   (rx_trig),
    .irq_id    (irq_id),
    .tout_pend (tout_pend)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 5;
    localparam int CHAR_CYC   = 4;
    localparam int TO_CHARS   = 4;
    localparam int LIMIT      = CHAR_CYC * TO_CHARS;

    logic clk = 0, rst = 1;
    logic fifo_en = 0, prog_thr_en = 0;
    logic [4:0] irq_en = 5'h1F;
    logic err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
    logic [LVL_W-1:0] rx_level = 0, rx_trig = 0, tx_level = 0, tx_thresh = 0;
    logic rx_push = 0, rx_pop = 0, thr_empty = 0;
    logic [3:0] modem_lines = 0;
    logic lcr_write = 0, busy = 0;
    logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, rd_msr = 0, rd_usr = 0, wr_thr = 0;
    logic [3:0] irq_id;
    logic irq;

    int checks = 0, fails = 0, cyc_cnt = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident #(.LVL_W(LVL_W), .CHAR_CYC(CHAR_CYC), .TO_CHARS(TO_CHARS)) u0 (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .prog_thr_en(prog_thr_en),
        .irq_en(irq_en), .err_overrun(err_overrun), .err_parity(err_parity),
        .err_framing(err_framing), .err_break(err_break), .rx_level(rx_level),
        .rx_trig(rx_trig), .rx_push(rx_push), .rx_pop(rx_pop), .thr_empty(thr_empty),
        .tx_level(tx_level), .tx_thresh(tx_thresh), .modem_lines(modem_lines),
        .lcr_write(lcr_write), .busy(busy), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
        .rd_iir(rd_iir), .rd_msr(rd_msr), .rd_usr(rd_usr), .wr_thr(wr_thr),
        .irq_id(irq_id), .irq(irq)
    );

    // behavioural reference state
    bit m_line, m_tx, m_mod, m_busy, m_to, m_txc_prev;
    logic [3:0] m_lines_prev;
    int m_idle;

    function automatic logic [3:0] exp_id();
        bit rxd;
        rxd = fifo_en ? (rx_level >= rx_trig) : (rx_level != 0);
        if (m_line && irq_en[2]) return 4'h6;
        if (rxd && irq_en[0])    return 4'h4;
        if (m_to && irq_en[0])   return 4'hC;
        if (m_tx && irq_en[1])   return 4'h2;
        if (m_mod && irq_en[3])  return 4'h0;
        if (m_busy && irq_en[4]) return 4'h7;
        return 4'h1;
    endfunction

    always @(posedge clk) begin
        logic [3:0] cid;
        bit txc, hit;
        if (rst) begin
            m_line = 0; m_tx = 0; m_mod = 0; m_busy = 0; m_to = 0;
            m_txc_prev = 0; m_lines_prev = 0; m_idle = 0;
        end else begin
            cid = exp_id();
            if (err_overrun || err_parity || err_framing || err_break) m_line = 1;
            else if (rd_lsr) m_line = 0;
            txc = prog_thr_en ? (tx_level <= tx_thresh) : thr_empty;
            if (txc && !m_txc_prev) m_tx = 1;
            else if (wr_thr || (rd_iir && cid == 4'h2)) m_tx = 0;
            m_txc_prev = txc;
            if (modem_lines != m_lines_prev) m_mod = 1;
            else if (rd_msr) m_mod = 0;
            m_lines_prev = modem_lines;
            if (lcr_write && busy) m_busy = 1;
            else if (rd_usr) m_busy = 0;
            hit = 0;
            if (fifo_en && rx_level != 0 && !rx_push && !rx_pop) begin
                m_idle++;
                hit = (m_idle == LIMIT);
            end else m_idle = 0;
            if (hit) m_to = 1;
            else if (rd_rbr) m_to = 0;
        end
    end

    task automatic check_now();
        logic [3:0] e;
        e = exp_id();
        checks++;
        if (irq_id !== e || irq !== (e != 4'h1)) begin
            fails++;
            $display("FAIL %s: irq_id=%h irq=%b expected irq_id=%h irq=%b",
                     cur_req, irq_id, irq, e, (e != 4'h1));
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst) check_now();
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected < 20000", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        // R1: reset state
        cur_req = "R1";
        cyc(1);
        checks++;
        if (irq_id !== 4'h1 || irq !== 1'b0) begin
            fails++;
            $display("FAIL R1: irq_id=%h irq=%b expected irq_id=1 irq=0", irq_id, irq);
        end
        cyc(3);

        // R7: modem change
        cur_req = "R7";
        modem_lines = 4'b0100; cyc(3);
        rd_msr = 1; cyc(1); rd_msr = 0; cyc(2);
        modem_lines = 4'b0000; cyc(2);
        rd_msr = 1; cyc(1); rd_msr = 0; cyc(2);

        // R8: busy detect
        cur_req = "R8";
        lcr_write = 1; cyc(1); lcr_write = 0; cyc(2);
        busy = 1; lcr_write = 1; cyc(1); lcr_write = 0; busy = 0; cyc(3);
        rd_usr = 1; cyc(1); rd_usr = 0; cyc(2);

        // R6: transmit empty, normal mode then threshold mode
        cur_req = "R6";
        thr_empty = 1; cyc(3);
        rd_iir = 1; cyc(1); rd_iir = 0; cyc(2);
        thr_empty = 0; cyc(1); thr_empty = 1; cyc(2);
        wr_thr = 1; cyc(1); wr_thr = 0; thr_empty = 0; cyc(2);
        prog_thr_en = 1; tx_level = 10; tx_thresh = 4; cyc(3);
        tx_level = 4; cyc(3);
        wr_thr = 1; cyc(1); wr_thr = 0; cyc(1);
        tx_level = 9; cyc(2);

        // R4: receive data level
        cur_req = "R4";
        rx_level = 1; cyc(2); rx_level = 0; cyc(2);
        fifo_en = 1; rx_trig = 4; rx_level = 3; rx_push = 1; cyc(1); rx_push = 0; cyc(2);
        rx_level = 4; rx_push = 1; cyc(1); rx_push = 0; cyc(2);
        rx_level = 3; rx_pop = 1; cyc(1); rx_pop = 0;

        // R5: character timeout with a restart
        cur_req = "R5";
        rx_trig = 8;
        cyc(LIMIT - 5);
        rx_level = 4; rx_push = 1; cyc(1); rx_push = 0;
        cyc(LIMIT + 4);
        rd_rbr = 1; cyc(1); rd_rbr = 0; cyc(4);
        rx_level = 0; rx_pop = 1; cyc(1); rx_pop = 0; cyc(2);

        // R3: each error type
        cur_req = "R3";
        err_parity = 1; cyc(1); err_parity = 0; cyc(2);
        rd_lsr = 1; cyc(1); rd_lsr = 0; cyc(1);
        err_framing = 1; cyc(1); err_framing = 0; rd_lsr = 1; cyc(1); rd_lsr = 0;
        err_break = 1; cyc(1); err_break = 0; rd_lsr = 1; cyc(1); rd_lsr = 0;
        err_overrun = 1; cyc(1); err_overrun = 0; rd_lsr = 1; cyc(1); rd_lsr = 0; cyc(1);

        // R11: set and clear together; R6 hidden-read case
        cur_req = "R11";
        err_overrun = 1; rd_lsr = 1; cyc(1); err_overrun = 0; rd_lsr = 0; cyc(2);
        tx_level = 2; cyc(1);
        rd_iir = 1; cyc(1); rd_iir = 0; cyc(1);
        rd_lsr = 1; cyc(1); rd_lsr = 0; cyc(2);
        busy = 1; lcr_write = 1; rd_usr = 1; cyc(1); busy = 0; lcr_write = 0; rd_usr = 0; cyc(1);

        // R2: all sources at once, serviced in order
        cur_req = "R2";
        modem_lines = 4'b1001; err_break = 1; rx_level = 9; rx_push = 1; cyc(1);
        err_break = 0; rx_push = 0; modem_lines = 4'b1001; cyc(2);
        rd_lsr = 1; cyc(1); rd_lsr = 0; cyc(1);
        rx_level = 2; rx_pop = 1; cyc(1); rx_pop = 0; cyc(LIMIT + 2);
        rd_rbr = 1; cyc(1); rd_rbr = 0; cyc(1);
        rd_iir = 1; cyc(1); rd_iir = 0; cyc(1);
        rd_msr = 1; cyc(1); rd_msr = 0; cyc(1);
        rd_usr = 1; cyc(1); rd_usr = 0; cyc(2);

        // R9: masked sources latch silently; R10 throughout
        cur_req = "R9";
        irq_en = 5'b00000;
        modem_lines = 4'b0000; busy = 1; lcr_write = 1; err_parity = 1; cyc(1);
        busy = 0; lcr_write = 0; err_parity = 0; cyc(3);
        irq_en = 5'b10000; cyc(2);
        irq_en = 5'b11000; cyc(2);
        irq_en = 5'b11100; cyc(2);
        irq_en = 5'b11111; cyc(2);
        cur_req = "R10";
        rd_lsr = 1; rd_msr = 1; rd_usr = 1; rx_level = 0; rx_pop = 1; cyc(1);
        rd_lsr = 0; rd_msr = 0; rd_usr = 0; rx_pop = 0; cyc(3);

        finish_run();
    end
endmodule